// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out buffer whose write side and read side run on two unrelated clocks. A producer pushes one word per write-clock edge by holding its active-low write enable; a consumer pulls one word per read-clock edge by holding its active-low read enable. Reads and writes may go on at the same time. The storage is an inferred two-port array with `2**AW` entries. The read and write pointers carry one extra wrap bit, and each pointer reaches the other clock domain as Gray code through a two-flop synchroniser.

Five active-low level flags report the fill state. Empty and almost-empty are registered on the read clock. Half-full, almost-full and full are registered on the write clock. The almost-empty and almost-full thresholds are offset inputs that a separate register block holds steady. A rewind input, sampled on the read clock, returns the read pointer to storage location 0. The words already in storage can then be read a second time, provided no more than `2**AW` words have been written since reset.

A single active-low reset clears both sides asynchronously. Each clock domain releases its own copy of the reset synchronously.

Top module: `twoclk_fifo`

## Requirements
- R1: Each rising `wr_clk` edge with `wr_en_n` low and `full_n` high stores `wr_data`, and words leave on `rd_data` in the order they were stored.
- R2: Each rising `rd_clk` edge with `rd_en_n` low, `empty_n` high and `rewind` low loads the oldest stored word into the `rd_data` register, where it is visible after that edge.
- R3: While `full_n` is low, a low `wr_en_n` stores nothing: no word is overwritten and the word count stays the same.
- R4: While `empty_n` is low, a low `rd_en_n` has no effect, and `rd_data` keeps the last word read.
- R5: `empty_n` is low exactly when the read-side count is 0, and it changes only on `rd_clk` edges.
- R6: `ae_n` is low when the read-side count is less than or equal to `ae_offset`.
- R7: `hf_n` is low when the write-side count is greater than `2**AW / 2`.
- R8: `af_n` is low when the write-side count is greater than or equal to `2**AW - af_offset` (with `af_offset` below `2**AW`).
- R9: `full_n` is low exactly when the write-side count equals `2**AW`, and it changes only on `wr_clk` edges.
- R10: While `rst_n` is low, the outputs are `empty_n`=0, `ae_n`=0, `hf_n`=1, `af_n`=1, `full_n`=1 and `rd_data`=0, and the buffer holds no words.
- R11: A high `rewind` on a `rd_clk` edge moves the read pointer to location 0 and blocks the read on that edge. The flags are recomputed from the new pointer, and the following reads return the stored words again from the first one.
- R12: With both clocks running and traffic on both sides, the flags never report space or data that is not there, so no word is lost, duplicated or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock, unrelated to `wr_clk` |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| wr_en_n | input | 1 | Active-low write request |
| wr_data | input | DW | Word to store |
| af_offset | input | AW+1 | Almost-full distance from full, quasi-static |
| rd_en_n | input | 1 | Active-low read request |
| rewind | input | 1 | Active-high request to restart reading at location 0 |
| ae_offset | input | AW+1 | Almost-empty threshold, quasi-static |
| rd_data | output | DW | Registered output word |
| empty_n | output | 1 | Low when no word is available (read clock) |
| ae_n | output | 1 | Low when the count is at or below `ae_offset` (read clock) |
| hf_n | output | 1 | Low when more than half the entries are used (write clock) |
| af_n | output | 1 | Low when the count reaches `2**AW - af_offset` (write clock) |
| full_n | output | 1 | Low when every entry is used (write clock) |

## Verification
Corruption of the write pointer or of its synchronised copy shows up as a wrong flag level on the next edge of the clock that owns that flag. Once the producer and consumer stop, the level also fails to match the true count. A read pointer that skips or stalls shows on `rd_data` at the very next read, as a word out of order or repeated, so every read is compared against a queue model. This holds both in quiet single-sided phases and under concurrent traffic on unrelated clocks. The rewind path is judged by its replayed data and by the flag levels right after the pulse.

// File: rtl/twoclk_fifo_pkg.sv
package twoclk_fifo_pkg;

  // Flags owned by the write clock domain
  typedef struct packed {
    logic full_n;
    logic af_n;
    logic hf_n;
  } wr_flags_t;

  // Flags owned by the read clock domain
  typedef struct packed {
    logic empty_n;
    logic ae_n;
  } rd_flags_t;

  localparam wr_flags_t WR_FLAGS_RST = '{full_n: 1'b1, af_n: 1'b1, hf_n: 1'b1};
  localparam rd_flags_t RD_FLAGS_RST = '{empty_n: 1'b0, ae_n: 1'b0};

endpackage

// File: rtl/twoclk_fifo_sync.sv
// Two-flop synchroniser; also used with d tied high as a reset release stage.
module twoclk_fifo_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end

endmodule

// File: rtl/twoclk_fifo_store.sv
// Inferred two-port storage: synchronous write, asynchronous read address.
module twoclk_fifo_store #(
  parameter int DW = 18,
  parameter int AW = 4
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/twoclk_fifo_wr_ctl.sv
// Write pointer and the write-domain flags (full, almost-full, half-full).
module twoclk_fifo_wr_ctl
  import twoclk_fifo_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_n,
  input  logic [AW:0]   rgray_s,
  input  logic [AW:0]   af_off,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output wr_flags_t     flags
);

  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] wbin_q, wbin_d;
  logic [PW-1:0] wgray_q, wgray_d;
  logic [PW-1:0] rbin_s;
  logic [PW-1:0] cnt_d;
  wr_flags_t     flags_q, flags_d;

  // Gray to binary for the synchronised read pointer
  always_comb begin
    for (int i = 0; i < PW; i++) begin
      rbin_s[i] = ^(rgray_s >> i);
    end
  end

  always_comb begin
    we              = !wr_en_n && flags_q.full_n;
    wbin_d          = wbin_q + PW'(we);
    wgray_d         = wbin_d ^ (wbin_d >> 1);
    cnt_d           = wbin_d - rbin_s;
    flags_d.full_n  = (cnt_d != PW'(DEPTH));
    flags_d.hf_n    = !(cnt_d > PW'(DEPTH / 2));
    flags_d.af_n    = !(cnt_d >= (PW'(DEPTH) - af_off));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      flags_q <= WR_FLAGS_RST;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
      flags_q <= flags_d;
    end
  end

  assign waddr = wbin_q[AW-1:0];
  assign wgray = wgray_q;
  assign flags = flags_q;

  // R3: a request while full must leave the write pointer where it was
  a_r3_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags_q.full_n && !wr_en_n) |=> (wbin_q == $past(wbin_q)));

  // R8: full implies almost-full
  a_r8_af_with_full: assert property (@(posedge clk) disable iff (!rst_n)
    !flags_q.full_n |-> !flags_q.af_n);

  // R7: full implies half-full
  a_r7_hf_with_full: assert property (@(posedge clk) disable iff (!rst_n)
    !flags_q.full_n |-> !flags_q.hf_n);

endmodule

// File: rtl/twoclk_fifo_rd_ctl.sv
// Read pointer, rewind, output register and the read-domain flags.
module twoclk_fifo_rd_ctl
  import twoclk_fifo_pkg::*;
#(
  parameter int DW = 18,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en_n,
  input  logic          rewind,
  input  logic [AW:0]   wgray_s,
  input  logic [AW:0]   ae_off,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic [DW-1:0] rd_data,
  output rd_flags_t     flags
);

  localparam int PW = AW + 1;

  logic [PW-1:0] rbin_q, rbin_d;
  logic [PW-1:0] rgray_q, rgray_d;
  logic [PW-1:0] wbin_s;
  logic [PW-1:0] cnt_d;
  logic [DW-1:0] rd_data_q, rd_data_d;
  logic          rd_do;
  rd_flags_t     flags_q, flags_d;

  always_comb begin
    for (int i = 0; i < PW; i++) begin
      wbin_s[i] = ^(wgray_s >> i);
    end
  end

  always_comb begin
    rd_do           = !rd_en_n && flags_q.empty_n && !rewind;
    rbin_d          = rewind ? '0 : (rbin_q + PW'(rd_do));
    rgray_d         = rbin_d ^ (rbin_d >> 1);
    cnt_d           = wbin_s - rbin_d;
    flags_d.empty_n = (cnt_d != '0);
    flags_d.ae_n    = !(cnt_d <= ae_off);
    rd_data_d       = rd_do ? mem_rdata : rd_data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q    <= '0;
      rgray_q   <= '0;
      rd_data_q <= '0;
      flags_q   <= RD_FLAGS_RST;
    end else begin
      rbin_q    <= rbin_d;
      rgray_q   <= rgray_d;
      rd_data_q <= rd_data_d;
      flags_q   <= flags_d;
    end
  end

  assign raddr   = rbin_q[AW-1:0];
  assign rgray   = rgray_q;
  assign rd_data = rd_data_q;
  assign flags   = flags_q;

  // R4: nothing moves and the output word holds while empty
  a_r4_hold_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags_q.empty_n && !rewind) |=> ((rbin_q == $past(rbin_q)) && $stable(rd_data_q)));

  // R6: empty implies almost-empty
  a_r6_ae_with_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !flags_q.empty_n |-> !flags_q.ae_n);

  // R11: rewind lands on location 0 with the wrap bit cleared
  a_r11_rewind_origin: assert property (@(posedge clk) disable iff (!rst_n)
    rewind |=> (rbin_q == '0));

endmodule

// File: rtl/twoclk_fifo.sv
module twoclk_fifo
  import twoclk_fifo_pkg::*;
#(
  parameter int DW = 18,
  parameter int AW = 4
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          wr_en_n,
  input  logic [DW-1:0] wr_data,
  input  logic [AW:0]   af_offset,
  input  logic          rd_en_n,
  input  logic          rewind,
  input  logic [AW:0]   ae_offset,
  output logic [DW-1:0] rd_data,
  output logic          empty_n,
  output logic          ae_n,
  output logic          hf_n,
  output logic          af_n,
  output logic          full_n
);

  localparam int PW = AW + 1;

  logic          wr_rst_n, rd_rst_n;
  logic          we;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic [DW-1:0] mem_rdata;
  wr_flags_t     wflags;
  rd_flags_t     rflags;

  twoclk_fifo_sync #(.W(1)) u_wr_rst (
    .clk(wr_clk), .rst_n(rst_n), .d(1'b1), .q(wr_rst_n)
  );

  twoclk_fifo_sync #(.W(1)) u_rd_rst (
    .clk(rd_clk), .rst_n(rst_n), .d(1'b1), .q(rd_rst_n)
  );

  twoclk_fifo_sync #(.W(PW)) u_w2r (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(wgray), .q(wgray_s)
  );

  twoclk_fifo_sync #(.W(PW)) u_r2w (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(rgray), .q(rgray_s)
  );

  twoclk_fifo_store #(.DW(DW), .AW(AW)) u_store (
    .wr_clk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(mem_rdata)
  );

  twoclk_fifo_wr_ctl #(.AW(AW)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .wr_en_n(wr_en_n), .rgray_s(rgray_s),
    .af_off(af_offset), .we(we), .waddr(waddr), .wgray(wgray), .flags(wflags)
  );

  twoclk_fifo_rd_ctl #(.DW(DW), .AW(AW)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .rd_en_n(rd_en_n), .rewind(rewind),
    .wgray_s(wgray_s), .ae_off(ae_offset), .mem_rdata(mem_rdata),
    .raddr(raddr), .rgray(rgray), .rd_data(rd_data), .flags(rflags)
  );

  assign empty_n = rflags.empty_n;
  assign ae_n    = rflags.ae_n;
  assign hf_n    = wflags.hf_n;
  assign af_n    = wflags.af_n;
  assign full_n  = wflags.full_n;

endmodule

// File: tb/tb_twoclk_fifo.sv
module tb_twoclk_fifo;

  localparam int DW    = 18;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  typedef struct packed {
    logic       rd;   // 1: read burst, 0: write burst
    logic [4:0] n;    // words attempted
    logic [4:0] fl;   // expected {empty_n, ae_n, hf_n, af_n, full_n}
  } vec_t;

  // Offsets 3/3: ae low at <=3, hf low above 8, af low at >=13, full at 16
  localparam vec_t VEC [12] = '{
    '{1'b0, 5'd1, 5'b10111},  // 1 word
    '{1'b0, 5'd2, 5'b10111},  // 3
    '{1'b0, 5'd1, 5'b11111},  // 4
    '{1'b0, 5'd5, 5'b11011},  // 9
    '{1'b0, 5'd4, 5'b11001},  // 13
    '{1'b0, 5'd3, 5'b11000},  // 16
    '{1'b0, 5'd2, 5'b11000},  // writes while full ignored
    '{1'b1, 5'd4, 5'b11011},  // 12
    '{1'b1, 5'd4, 5'b11111},  // 8
    '{1'b1, 5'd5, 5'b10111},  // 3
    '{1'b1, 5'd3, 5'b00111},  // 0
    '{1'b1, 5'd2, 5'b00111}   // reads while empty ignored
  };

  logic          wr_clk = 1'b0;
  logic          rd_clk = 1'b0;
  logic          rst_n;
  logic          wr_en_n;
  logic [DW-1:0] wr_data;
  logic          rd_en_n;
  logic          rewind;
  logic [DW-1:0] rd_data;
  logic          empty_n, ae_n, hf_n, af_n, full_n;
  logic [AW:0]   af_offset = 5'd3;
  logic [AW:0]   ae_offset = 5'd3;

  always #10 wr_clk = ~wr_clk;
  always #17 rd_clk = ~rd_clk;

  twoclk_fifo #(.DW(DW), .AW(AW)) dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
    .wr_en_n(wr_en_n), .wr_data(wr_data), .af_offset(af_offset),
    .rd_en_n(rd_en_n), .rewind(rewind), .ae_offset(ae_offset),
    .rd_data(rd_data), .empty_n(empty_n), .ae_n(ae_n), .hf_n(hf_n),
    .af_n(af_n), .full_n(full_n)
  );

  int nchk  = 0;
  int nfail = 0;
  bit done  = 1'b0;
  int seq   = 0;
  logic [DW-1:0] model [$];
  logic [DW-1:0] hist  [$];
  logic [DW-1:0] last_rd;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_flags(input logic [4:0] e, input string where);
    chk(empty_n == e[4], {"R5 empty_n ", where}, int'(empty_n), int'(e[4]));
    chk(ae_n    == e[3], {"R6 ae_n ",    where}, int'(ae_n),    int'(e[3]));
    chk(hf_n    == e[2], {"R7 hf_n ",    where}, int'(hf_n),    int'(e[2]));
    chk(af_n    == e[1], {"R8 af_n ",    where}, int'(af_n),    int'(e[1]));
    chk(full_n  == e[0], {"R9 full_n ",  where}, int'(full_n),  int'(e[0]));
  endtask

  task automatic settle();
    repeat (6) @(negedge wr_clk);
    repeat (6) @(negedge rd_clk);
  endtask

  task automatic do_reset(input string where);
    rst_n   = 1'b0;
    wr_en_n = 1'b1;
    rd_en_n = 1'b1;
    rewind  = 1'b0;
    repeat (3) @(negedge wr_clk);
    // R10: reset state while reset is held
    chk({empty_n, ae_n, hf_n, af_n, full_n} == 5'b00111, {"R10 flags ", where},
        int'({empty_n, ae_n, hf_n, af_n, full_n}), int'(5'b00111));
    chk(rd_data == '0, {"R10 rd_data ", where}, int'(rd_data), 0);
    rst_n = 1'b1;
    model.delete();
    hist.delete();
    last_rd = '0;
    settle();
  endtask

  task automatic do_write(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge wr_clk);
      wr_data = DW'(seq * 73 + 11);
      seq++;
      wr_en_n = 1'b0;
      if (model.size() < DEPTH) begin
        model.push_back(wr_data);
        hist.push_back(wr_data);
      end
    end
    @(negedge wr_clk);
    wr_en_n = 1'b1;
  endtask

  task automatic do_read(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      string t;
      @(negedge rd_clk);
      rd_en_n = 1'b0;
      @(negedge rd_clk);
      rd_en_n = 1'b1;
      if (model.size() > 0) begin
        t = tag;
        last_rd = model.pop_front();
      end else begin
        t = "R4 hold while empty";
      end
      chk(rd_data == last_rd, t, int'(rd_data), int'(last_rd));
    end
  endtask

  initial begin
    wr_data = '0;
    do_reset("initial");

    // Table walk: fill to full, overfill, drain to empty, overdrain
    for (int i = 0; i < 12; i++) begin
      if (VEC[i].rd) do_read(int'(VEC[i].n), "R1 R2 read order");
      else           do_write(int'(VEC[i].n));
      settle();
      check_flags(VEC[i].fl, $sformatf("vector %0d", i));
    end

    // Reset with data inside clears to the empty state (R10)
    do_write(6);
    settle();
    do_reset("with data");
    check_flags(5'b00111, "after reset");

    // R11: rewind replays stored words from location 0
    do_write(5);
    settle();
    do_read(2, "R2 before rewind");
    @(negedge rd_clk);
    rewind = 1'b1;
    @(negedge rd_clk);
    rewind = 1'b0;
    model.delete();
    foreach (hist[j]) model.push_back(hist[j]);
    settle();
    chk({empty_n, ae_n, hf_n} == 3'b111, "R11 flags after rewind",
        int'({empty_n, ae_n, hf_n}), int'(3'b111));
    do_read(5, "R11 replay data");
    settle();
    chk(empty_n == 1'b0, "R11 empty after replay", int'(empty_n), 0);

    // R12: concurrent traffic on unrelated clocks, flag-driven handshake
    do_reset("before concurrent");
    fork
      begin : writer
        int k = 0;
        while (k < 40) begin
          @(negedge wr_clk);
          if (full_n) begin
            wr_data = DW'(seq * 73 + 11);
            seq++;
            wr_en_n = 1'b0;
            model.push_back(wr_data);
            k++;
          end else begin
            wr_en_n = 1'b1;
          end
        end
        @(negedge wr_clk);
        wr_en_n = 1'b1;
      end
      begin : reader
        int k   = 0;
        int cyc = 0;
        bit pend = 1'b0;
        while (k < 40 || pend) begin
          @(negedge rd_clk);
          cyc++;
          if (pend) begin
            last_rd = model.pop_front();
            chk(rd_data == last_rd, "R12 R1 concurrent order",
                int'(rd_data), int'(last_rd));
            pend = 1'b0;
          end
          if (k < 40 && empty_n && (cyc % 4 != 3)) begin
            rd_en_n = 1'b0;
            pend = 1'b1;
            k++;
          end else begin
            rd_en_n = 1'b1;
          end
        end
      end
    join
    settle();
    check_flags(5'b00111, "after concurrent");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge wr_clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog R12 actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

endmodule